// File: doc/BRIEF.md
# Two-Stage SPI Bit-Clock Prescaler

This block derives the serial bit clock of an SPI master from the system clock. It uses two dividers in series. The first stage divides by a power of four: 1, 4, 16 or 64. The second stage counts the first stage's ticks and divides them by an integer from one to eight. The overall ratio is therefore the product of the two stage ratios, from 1 up to 512 system-clock cycles per bit-clock tick.

Both select codes are inverted, so the all-ones code gives the fastest setting. The block drives two outputs:

- a one-cycle `bit_tick` strobe at every terminal count of the combined divider, which shift logic can use as a clock enable;
- a serial clock `sclk` that toggles on each such strobe, so its duty cycle is 50%.

The block runs only while it is enabled and the port acts as master. In any other state its counters stay cleared and `sclk` rests low. The select codes are sampled at a terminal count or while the block is idle, so a code change never shortens a clock phase.

Top module: `spi_bitclk_prescaler`

## Requirements
- R1: The primary code `pri_code` selects the first-stage ratio: 2'b11 gives 1, 2'b10 gives 4, 2'b01 gives 16 and 2'b00 gives 64.
- R2: The secondary code `sec_code` selects the second-stage ratio as its bitwise inverse plus one: 3'b111 gives 1, 3'b110 gives 2, and so on down to 3'b000, which gives 8.
- R3: While running, `bit_tick` is high for exactly one cycle every P*S system-clock cycles, where P and S are the two stage ratios. The first tick comes P*S cycles after the first rising edge at which the block runs.
- R4: `sclk` toggles in the same cycle that `bit_tick` is high and at no other time while running, so each of its phases lasts P*S cycles.
- R5: When `en` is low or `master` is low, one clock edge later `sclk` is 0 and `bit_tick` is 0, and both counters restart from zero.
- R6: A code change made while running takes effect only after the next terminal count. The interval in progress completes at the old ratio.
- R7: While `rst` is high, `bit_tick` and `sclk` are 0.
- R8: With both codes all-ones, `bit_tick` is high on every cycle while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| master | input | 1 | High when the port operates as master |
| pri_code | input | 2 | Power-of-four stage select (inverted code) |
| sec_code | input | 3 | One-to-eight stage select (inverted code) |
| bit_tick | output | 1 | One-cycle strobe at each combined terminal count |
| sclk | output | 1 | Serial clock, idle low |

## Verification
Some properties are checked by assertions on every cycle:

- each counter stays within the range set by its latched code;
- the secondary counter only moves when the primary stage ticks;
- `sclk` flips whenever `bit_tick` is high, and falls to idle one edge after the block stops;
- the latched codes hold between terminal counts.

Other behaviour can only be shown by the bench's scenarios: the actual interval lengths for each code pair, the start-up latency after enabling, the old ratio finishing before a mid-interval code change takes effect, and the absence of ticks in slave mode.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;
  localparam int PRI_CODE_W = 2;
  localparam int SEC_CODE_W = 3;
  localparam logic SCLK_IDLE = 1'b0;
endpackage

// File: rtl/presc_pow4_stage.sv
module presc_pow4_stage #(
  parameter int CODE_W = spi_presc_pkg::PRI_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int CNT_W = 2 * ((1 << CODE_W) - 1);
  localparam int RAT_W = CNT_W + 1;

  logic [CODE_W-1:0] inv_code;
  logic [RAT_W-1:0]  ratio_m1;
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    inv_code = ~code;
    ratio_m1 = (RAT_W'(1) << (2 * inv_code)) - RAT_W'(1);
    tick     = run && (cnt == ratio_m1[CNT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + CNT_W'(1);
  end

  AST_PRI_BOUND: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt} <= ratio_m1); // R1
endmodule

// File: rtl/presc_lin_stage.sv
module presc_lin_stage #(
  parameter int CODE_W = spi_presc_pkg::SEC_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              step,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [CODE_W-1:0] cnt;

  // ratio minus one equals the inverted code
  always_comb tick = run && step && (cnt == ~code);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else if (step)           cnt <= cnt + CODE_W'(1);
  end

  AST_SEC_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= ~code); // R2
  AST_SEC_STEP_ONLY: assert property (@(posedge clk) disable iff (rst)
    run && !step |=> cnt == $past(cnt)); // R3
endmodule

// File: rtl/presc_sclk_out.sv
module presc_sclk_out (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic term,
  output logic bit_tick,
  output logic sclk
);
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      bit_tick <= 1'b0;
      sclk     <= spi_presc_pkg::SCLK_IDLE;
    end else begin
      bit_tick <= term;
      sclk     <= sclk ^ term;
    end
  end

  AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sclk != $past(sclk)); // R4
  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (rst)
    !run |=> (sclk == spi_presc_pkg::SCLK_IDLE) && !bit_tick); // R5
endmodule

// File: rtl/spi_bitclk_prescaler.sv
module spi_bitclk_prescaler #(
  parameter int PRI_W = spi_presc_pkg::PRI_CODE_W,
  parameter int SEC_W = spi_presc_pkg::SEC_CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             master,
  input  logic [PRI_W-1:0] pri_code,
  input  logic [SEC_W-1:0] sec_code,
  output logic             bit_tick,
  output logic             sclk
);
  logic             run;
  logic             pri_tick;
  logic             term;
  logic [PRI_W-1:0] pri_lat;
  logic [SEC_W-1:0] sec_lat;

  always_comb run = en && master;

  // codes are sampled only while idle or at a combined terminal count
  always_ff @(posedge clk) begin
    if (rst || !run || term) begin
      pri_lat <= pri_code;
      sec_lat <= sec_code;
    end
  end

  presc_pow4_stage #(.CODE_W(PRI_W)) u_pri (
    .clk (clk), .rst (rst), .run (run), .code (pri_lat), .tick (pri_tick)
  );

  presc_lin_stage #(.CODE_W(SEC_W)) u_sec (
    .clk (clk), .rst (rst), .run (run), .step (pri_tick), .code (sec_lat),
    .tick (term)
  );

  presc_sclk_out u_out (
    .clk (clk), .rst (rst), .run (run), .term (term),
    .bit_tick (bit_tick), .sclk (sclk)
  );

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(run) && !$past(term)
      |-> $stable(pri_lat) && $stable(sec_lat)); // R6
  AST_TERM_NEEDS_PRI: assert property (@(posedge clk) disable iff (rst)
    term |-> pri_tick); // R3
endmodule

// File: tb/spi_bitclk_prescaler_tb.sv
module spi_bitclk_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       master = 1'b1;
  logic [1:0] pri_code = 2'b11;
  logic [2:0] sec_code = 3'b111;
  logic       bit_tick;
  logic       sclk;
  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  spi_bitclk_prescaler u_dut (
    .clk (clk), .rst (rst), .en (en), .master (master),
    .pri_code (pri_code), .sec_code (sec_code),
    .bit_tick (bit_tick), .sclk (sclk)
  );

  // {pri_code, sec_code, expected cycles per tick}
  localparam logic [14:0] VEC [9] = '{
    {2'b11, 3'b111, 10'd1},  {2'b11, 3'b110, 10'd2},  {2'b10, 3'b111, 10'd4},
    {2'b01, 3'b101, 10'd48}, {2'b00, 3'b111, 10'd64}, {2'b00, 3'b000, 10'd512},
    {2'b10, 3'b011, 10'd20}, {2'b11, 3'b000, 10'd8},  {2'b01, 3'b111, 10'd16}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!bit_tick && n < 2000);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    int r;
    // R7: reset holds outputs low even when enabled as master
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk(bit_tick == 1'b0, "R7 bit_tick in reset", bit_tick, 0);
    chk(sclk == 1'b0, "R7 sclk in reset", sclk, 0);
    en = 1'b0; rst = 1'b0;
    @(negedge clk);

    // R1 R2 R3 R4 vector walk
    for (int i = 0; i < 9; i++) begin
      en = 1'b0;
      pri_code = VEC[i][14:13];
      sec_code = VEC[i][12:10];
      r = int'(VEC[i][9:0]);
      repeat (2) @(negedge clk);
      en = 1'b1;
      wait_tick(n);
      chk(n == r, "R1 R2 R3 first tick latency", n, r);
      chk(sclk == 1'b1, "R4 sclk after first tick", sclk, 1);
      wait_tick(n);
      chk(n == r, "R1 R2 R3 tick interval", n, r);
      chk(sclk == 1'b0, "R4 sclk after second tick", sclk, 0);
    end

    // R8: divide-by-1 ticks on every cycle
    en = 1'b0; pri_code = 2'b11; sec_code = 3'b111;
    repeat (2) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      chk(bit_tick == 1'b1, "R8 tick every cycle", bit_tick, 1);
      chk(sclk == ((k % 2) == 0), "R8 R4 sclk alternates", sclk, (k % 2) == 0);
      @(negedge clk);
    end

    // R5: slave mode stays idle
    en = 1'b0; pri_code = 2'b10; sec_code = 3'b111;
    @(negedge clk);
    master = 1'b0; en = 1'b1;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (bit_tick || sclk) n++;
    end
    chk(n == 0, "R5 slave mode idle cycles", n, 0);

    // R5: dropping enable mid-run idles sclk and restarts counters
    master = 1'b1;
    wait_tick(n);
    chk(sclk == 1'b1, "R5 sclk high before disable", sclk, 1);
    en = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R5 sclk idle after disable", sclk, 0);
    chk(bit_tick == 1'b0, "R5 no tick after disable", bit_tick, 0);
    en = 1'b1;
    wait_tick(n);
    chk(n == 4, "R5 restart latency", n, 4);

    // R6: mid-interval code change waits for the terminal count
    en = 1'b0; pri_code = 2'b00; sec_code = 3'b111;
    repeat (2) @(negedge clk);
    en = 1'b1;
    wait_tick(n);
    repeat (10) @(negedge clk);
    pri_code = 2'b11;
    n = 10;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!bit_tick && n < 2000);
    chk(n == 64, "R6 old ratio completes", n, 64);
    wait_tick(n);
    chk(n == 1, "R6 new ratio applied", n, 1);

    finish_run();
  end
endmodule